// File: doc/BRIEF.md
# PCI Target Access-Width Checker

This block sits beside the target state machine of a PCI function that hosts several internal destinations: legacy byte-wide peripherals, an audio codec window, a host/DSP download port, a DMA I/O window, a memory-mapped register window and a set of configuration registers. Each destination accepts only certain byte-enable patterns and certain bus commands. In every data phase the block compares the bus command and the active-low byte enables with the destination that the address decoder has selected. It then tells the target state machine to complete the cycle or to end it with a target abort.

A one-cycle `dataValid` strobe marks the data phase in which the command, the destination select and the byte enables are valid. Exactly one clock later the block raises either `acceptStb` or `abortReq` for one cycle. A cycle that this device's own master started and that is aimed back at this device is always aborted, and `selfAccessErr` is raised with the abort. A cycle that hits no destination produces no response at all, so it can end in a master abort elsewhere.

The byte enables are sorted into classes, with lane 0 at bit 0 and an asserted enable driven as 0:
- none asserted;
- one asserted (byte);
- lanes 0–1 (low half);
- lanes 2–3 (high half);
- lanes 1–2 (misaligned half);
- all four (word);
- any other pattern.

Top module: `pci_width_guard`

## Requirements
- R1: The byte-only destinations accept only an I/O command with exactly one byte enable asserted. These are the game port (destSel bit 0), the legacy sound registers (bit 1), the MIDI interface (bit 2) and the UART (bit 3). Any other pattern, including none or all enables, aborts.
- R2: The codec window (bit 4) accepts only an I/O command with beN 4'b1100 or 4'b0011. Any other pattern aborts.
- R3: The host/DSP port (bit 5) accepts I/O with a single enable or an aligned half (beN 4'b1100 or 4'b0011). The misaligned half beN 4'b1001 aborts, and so do no enables, three enables and a full word.
- R4: The DMA I/O window (bit 6) accepts any byte-enable pattern on an I/O command. The virtual-register window (bit 7) accepts any pattern on a memory read.
- R5: Under a configuration command:
  - the general configuration space (bit 8) accepts any pattern;
  - the PLL register (bit 9) accepts only a single enable;
  - the table-base registers (bit 10) accept only beN 4'b0000;
  - the virtual-register configuration register (bit 11) accepts only beN 4'b1100 or 4'b0011.
- R6: A command outside the destination's class aborts. The I/O commands are 4'h2 and 4'h3, the only memory command allowed is memory read 4'h6, and the configuration commands are 4'hA and 4'hB. This covers configuration space reached by an I/O or memory command, a memory write, and any other command.
- R7: When `ownMasterCyc` is high with `dataValid`, the block raises `abortReq` and `selfAccessErr` together, whatever the destination and byte enables are.
- R8: When `dataValid` is high, destSel is zero and `ownMasterCyc` is low, the block raises neither `acceptStb` nor `abortReq`.
- R9: A destSel with more than one bit set aborts.
- R10: The response appears exactly one clock after `dataValid` and lasts one cycle. `acceptStb` and `abortReq` are never high together, and neither rises without `dataValid` in the previous cycle.
- R11: While `rstN` is low at a clock edge, all three outputs are low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| dataValid | input | 1 | One-cycle data-phase strobe |
| ownMasterCyc | input | 1 | Cycle was started by this device's own master |
| busCmd | input | 4 | PCI bus command of the cycle |
| destSel | input | 12 | One-hot destination from the address decoder |
| beN | input | 4 | Active-low byte enables |
| acceptStb | output | 1 | Complete the access (registered, one cycle) |
| abortReq | output | 1 | Request target abort (registered, one cycle) |
| selfAccessErr | output | 1 | Illegal self-access flagged (registered, one cycle) |

## Verification
The bench sends every destination a legal pattern and at least one illegal one. The pairs are chosen so that each accept/abort boundary is crossed from both sides: byte against half, aligned half against the lanes 1–2 half, word against half, and none against any. It then keeps a width that would be legal and changes only the command, which shows that command class is checked apart from width. Self-access, miss and multi-hit rows show the priority order. Directed sequences cover reset, an idle cycle, the one-cycle pulse width and two valid cycles back to back.

// File: rtl/accw_pkg.sv
package accw_pkg;
  localparam int BE_W   = 4;
  localparam int DEST_N = 12;
  localparam int CLS_N  = 7;

  typedef enum logic [2:0] {
    WC_NONE, WC_BYTE, WC_HALF_LO, WC_HALF_HI, WC_HALF_MID, WC_WORD, WC_OTHER
  } widthCls_e;

  typedef enum logic [1:0] {CC_NONE, CC_IO, CC_MEMRD, CC_CFG} cmdCls_e;

  typedef logic [CLS_N-1:0] clsMask_t;

  typedef struct packed {
    cmdCls_e  needCmd;
    clsMask_t allow;
  } destRule_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAccept;
    logic loadAbort;
    logic loadSelf;
  } ctrlStb_t;

  // destination bit positions in destSel (decoder contract)
  localparam int D_GAME   = 0;
  localparam int D_SBLEG  = 1;
  localparam int D_MIDI   = 2;
  localparam int D_UART   = 3;
  localparam int D_CODEC  = 4;
  localparam int D_HOST   = 5;
  localparam int D_DMA    = 6;
  localparam int D_VREG   = 7;
  localparam int D_CFG    = 8;
  localparam int D_PLL    = 9;
  localparam int D_TBL    = 10;
  localparam int D_VRCFG  = 11;

  localparam clsMask_t M_ANY  = '1;
  localparam clsMask_t M_BYTE = clsMask_t'(1) << WC_BYTE;
  localparam clsMask_t M_HALF = (clsMask_t'(1) << WC_HALF_LO) | (clsMask_t'(1) << WC_HALF_HI);
  localparam clsMask_t M_WORD = clsMask_t'(1) << WC_WORD;

  function automatic destRule_t ruleFor(int idx);
    destRule_t r;
    case (idx)
      D_GAME, D_SBLEG, D_MIDI, D_UART: r = '{CC_IO, M_BYTE};
      D_CODEC: r = '{CC_IO, M_HALF};
      D_HOST:  r = '{CC_IO, M_BYTE | M_HALF};
      D_DMA:   r = '{CC_IO, M_ANY};
      D_VREG:  r = '{CC_MEMRD, M_ANY};
      D_CFG:   r = '{CC_CFG, M_ANY};
      D_PLL:   r = '{CC_CFG, M_BYTE};
      D_TBL:   r = '{CC_CFG, M_WORD};
      D_VRCFG: r = '{CC_CFG, M_HALF};
      default: r = '{CC_IO, '0};
    endcase
    return r;
  endfunction

  function automatic widthCls_e classifyBe(logic [BE_W-1:0] beN);
    logic [BE_W-1:0] en;
    widthCls_e c;
    en = ~beN;
    case (en)
      4'b0000: c = WC_NONE;
      4'b0001, 4'b0010, 4'b0100, 4'b1000: c = WC_BYTE;
      4'b0011: c = WC_HALF_LO;
      4'b1100: c = WC_HALF_HI;
      4'b0110: c = WC_HALF_MID;
      4'b1111: c = WC_WORD;
      default: c = WC_OTHER;
    endcase
    return c;
  endfunction

  function automatic cmdCls_e classifyCmd(logic [3:0] cmd);
    cmdCls_e c;
    case (cmd)
      4'h2, 4'h3: c = CC_IO;
      4'h6:       c = CC_MEMRD;
      4'hA, 4'hB: c = CC_CFG;
      default:    c = CC_NONE;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/accw_width_path.sv
module accw_width_path
  import accw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        busCmd,
  input  logic [DEST_N-1:0] destSel,
  input  logic [BE_W-1:0]   beN,
  input  ctrlStb_t          stb,
  output logic              hitAny,
  output logic              hitMulti,
  output logic              hitLegal,
  output logic              acceptStb,
  output logic              abortReq,
  output logic              selfAccessErr
);
  widthCls_e         wCls;
  cmdCls_e           cCls;
  logic [DEST_N-1:0] legalVec;

  always_comb begin
    wCls = classifyBe(beN);
    cCls = classifyCmd(busCmd);
  end

  for (genvar g = 0; g < DEST_N; g++) begin : gRule
    localparam destRule_t RULE = ruleFor(g);
    assign legalVec[g] = (cCls == RULE.needCmd) && RULE.allow[wCls];
  end

  always_comb begin
    hitAny   = |destSel;
    hitMulti = |(destSel & (destSel - 1'b1));
    hitLegal = |(destSel & legalVec);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acceptStb     <= 1'b0;
      abortReq      <= 1'b0;
      selfAccessErr <= 1'b0;
    end else begin
      acceptStb     <= stb.loadAccept;
      abortReq      <= stb.loadAbort;
      selfAccessErr <= stb.loadSelf;
    end
  end

  p_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(acceptStb && abortReq));
  p_self_with_abort_r7: assert property (@(posedge clk) disable iff (!rstN)
    selfAccessErr |-> abortReq);
endmodule

// File: rtl/accw_seq_ctrl.sv
module accw_seq_ctrl
  import accw_pkg::*;
(
  input  logic     sampleValid,
  input  logic     ownMasterCyc,
  input  logic     hitAny,
  input  logic     hitMulti,
  input  logic     hitLegal,
  output ctrlStb_t stb
);
  typedef enum logic [2:0] {DEC_IDLE, DEC_SELF, DEC_MISS, DEC_CONFLICT, DEC_OK, DEC_REJECT} decision_e;
  decision_e decision;

  // priority: self-access, miss, multi-hit, rule check
  always_comb begin
    if (!sampleValid)      decision = DEC_IDLE;
    else if (ownMasterCyc) decision = DEC_SELF;
    else if (!hitAny)      decision = DEC_MISS;
    else if (hitMulti)     decision = DEC_CONFLICT;
    else if (hitLegal)     decision = DEC_OK;
    else                   decision = DEC_REJECT;
  end

  always_comb begin
    stb = '0;
    case (decision)
      DEC_SELF:     begin stb.loadAbort = 1'b1; stb.loadSelf = 1'b1; end
      DEC_CONFLICT: stb.loadAbort  = 1'b1;
      DEC_REJECT:   stb.loadAbort  = 1'b1;
      DEC_OK:       stb.loadAccept = 1'b1;
      default:      stb = '0;
    endcase
  end

  always_comb begin
    p_strobe_excl_r10: assert (!(stb.loadAccept && stb.loadAbort));
    p_miss_silent_r8: assert (!(sampleValid && !ownMasterCyc && !hitAny) ||
                              !(stb.loadAccept || stb.loadAbort));
  end
endmodule

// File: rtl/pci_width_guard.sv
module pci_width_guard
  import accw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataValid,
  input  logic              ownMasterCyc,
  input  logic [3:0]        busCmd,
  input  logic [DEST_N-1:0] destSel,
  input  logic [BE_W-1:0]   beN,
  output logic              acceptStb,
  output logic              abortReq,
  output logic              selfAccessErr
);
  ctrlStb_t stb;
  logic     hitAny, hitMulti, hitLegal;

  accw_width_path uPath (
    .clk(clk), .rstN(rstN), .busCmd(busCmd), .destSel(destSel), .beN(beN),
    .stb(stb), .hitAny(hitAny), .hitMulti(hitMulti), .hitLegal(hitLegal),
    .acceptStb(acceptStb), .abortReq(abortReq), .selfAccessErr(selfAccessErr)
  );

  accw_seq_ctrl uCtrl (
    .sampleValid(dataValid), .ownMasterCyc(ownMasterCyc), .hitAny(hitAny),
    .hitMulti(hitMulti), .hitLegal(hitLegal), .stb(stb)
  );

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(dataValid) |-> !acceptStb && !abortReq);
  p_self_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(dataValid && rstN && ownMasterCyc) |-> abortReq && selfAccessErr);
  p_nohit_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(dataValid && rstN && !ownMasterCyc && destSel == '0) |-> !acceptStb && !abortReq);
  p_multi_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(dataValid && rstN && !ownMasterCyc && $countones(destSel) > 1) |-> abortReq);
  p_host_mid_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(dataValid && rstN && !ownMasterCyc && destSel == (DEST_N'(1) << D_HOST) && beN == 4'b1001)
    |-> abortReq);
  p_game_byte_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(dataValid && rstN && !ownMasterCyc && destSel == (DEST_N'(1) << D_GAME)
          && busCmd == 4'h2 && beN == 4'b1110) |-> acceptStb);
  p_reset_r11: assert property (@(posedge clk)
    !rstN |=> !acceptStb && !abortReq && !selfAccessErr);
endmodule

// File: tb/tb_pci_width_guard.sv
module tb_pci_width_guard;
  localparam int DN = accw_pkg::DEST_N;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dataValid = 1'b0;
  logic ownMasterCyc = 1'b0;
  logic [3:0] busCmd = 4'h0;
  logic [DN-1:0] destSel = '0;
  logic [3:0] beN = 4'hF;
  logic acceptStb, abortReq, selfAccessErr;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  pci_width_guard dut (
    .clk(clk), .rstN(rstN), .dataValid(dataValid), .ownMasterCyc(ownMasterCyc),
    .busCmd(busCmd), .destSel(destSel), .beN(beN),
    .acceptStb(acceptStb), .abortReq(abortReq), .selfAccessErr(selfAccessErr)
  );

  // {req[3:0], cmd[3:0], dest[11:0], beN[3:0], self, expAcc, expAbt, expSelf}
  localparam int NV = 33;
  localparam logic [27:0] VEC [NV] = '{
    {4'd1, 4'h2, 12'h001, 4'b1110, 1'b0, 3'b100},  // R1 game byte
    {4'd1, 4'h3, 12'h001, 4'b1100, 1'b0, 3'b010},  // R1 game half
    {4'd1, 4'h3, 12'h008, 4'b0111, 1'b0, 3'b100},  // R1 uart byte lane3
    {4'd1, 4'h2, 12'h004, 4'b0000, 1'b0, 3'b010},  // R1 midi word
    {4'd1, 4'h2, 12'h002, 4'b1111, 1'b0, 3'b010},  // R1 legacy none
    {4'd2, 4'h2, 12'h010, 4'b1100, 1'b0, 3'b100},  // R2 codec low half
    {4'd2, 4'h3, 12'h010, 4'b0011, 1'b0, 3'b100},  // R2 codec high half
    {4'd2, 4'h2, 12'h010, 4'b1110, 1'b0, 3'b010},  // R2 codec byte
    {4'd2, 4'h2, 12'h010, 4'b0000, 1'b0, 3'b010},  // R2 codec word
    {4'd3, 4'h2, 12'h020, 4'b1101, 1'b0, 3'b100},  // R3 host byte
    {4'd3, 4'h3, 12'h020, 4'b0011, 1'b0, 3'b100},  // R3 host high half
    {4'd3, 4'h2, 12'h020, 4'b1001, 1'b0, 3'b010},  // R3 host misaligned
    {4'd3, 4'h2, 12'h020, 4'b0000, 1'b0, 3'b010},  // R3 host word
    {4'd4, 4'h2, 12'h040, 4'b1010, 1'b0, 3'b100},  // R4 dma non-contiguous
    {4'd4, 4'h3, 12'h040, 4'b1111, 1'b0, 3'b100},  // R4 dma none
    {4'd4, 4'h6, 12'h080, 4'b0101, 1'b0, 3'b100},  // R4 vreg odd pattern
    {4'd5, 4'hA, 12'h100, 4'b1000, 1'b0, 3'b100},  // R5 cfg three lanes
    {4'd5, 4'hB, 12'h200, 4'b1011, 1'b0, 3'b100},  // R5 pll byte
    {4'd5, 4'hB, 12'h200, 4'b1100, 1'b0, 3'b010},  // R5 pll half
    {4'd5, 4'hA, 12'h400, 4'b0000, 1'b0, 3'b100},  // R5 table word
    {4'd5, 4'hB, 12'h400, 4'b1100, 1'b0, 3'b010},  // R5 table half
    {4'd5, 4'hA, 12'h800, 4'b0011, 1'b0, 3'b100},  // R5 vrcfg aligned half
    {4'd5, 4'hA, 12'h800, 4'b1001, 1'b0, 3'b010},  // R5 vrcfg misaligned
    {4'd5, 4'hA, 12'h800, 4'b1110, 1'b0, 3'b010},  // R5 vrcfg byte
    {4'd6, 4'h6, 12'h001, 4'b1110, 1'b0, 3'b010},  // R6 game by memory read
    {4'd6, 4'h2, 12'h100, 4'b0000, 1'b0, 3'b010},  // R6 cfg by I/O
    {4'd6, 4'h7, 12'h080, 4'b0000, 1'b0, 3'b010},  // R6 vreg memory write
    {4'd6, 4'hB, 12'h010, 4'b1100, 1'b0, 3'b010},  // R6 codec by cfg
    {4'd6, 4'h0, 12'h040, 4'b0000, 1'b0, 3'b010},  // R6 dma other command
    {4'd7, 4'h2, 12'h010, 4'b1100, 1'b1, 3'b011},  // R7 self on legal access
    {4'd7, 4'h2, 12'h000, 4'b1110, 1'b1, 3'b011},  // R7 self with no hit
    {4'd8, 4'h2, 12'h000, 4'b1110, 1'b0, 3'b000},  // R8 miss
    {4'd9, 4'h2, 12'h009, 4'b1110, 1'b0, 3'b010}   // R9 two destinations
  };

  task automatic checkOut(input string tag, input logic [2:0] exp);
    logic [2:0] act;
    act = {acceptStb, abortReq, selfAccessErr};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s acc/abt/self actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // drive at negedge, valid for one cycle; response sampled at next negedge
  task automatic issue(input logic [3:0] c, input logic [DN-1:0] d,
                       input logic [3:0] b, input logic s);
    @(negedge clk);
    busCmd = c; destSel = d; beN = b; ownMasterCyc = s; dataValid = 1'b1;
    @(negedge clk);
    dataValid = 1'b0; ownMasterCyc = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkOut("R11 reset state", 3'b000);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R10 idle after reset", 3'b000);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][23:20], VEC[i][19:8], VEC[i][7:4], VEC[i][3]);
      checkOut($sformatf("R%0d vector %0d", VEC[i][27:24], i), VEC[i][2:0]);
    end

    // R10: legal inputs without valid produce nothing
    @(negedge clk);
    busCmd = 4'h2; destSel = 12'h001; beN = 4'b1110; dataValid = 1'b0;
    @(negedge clk);
    checkOut("R10 no valid no response", 3'b000);

    // R10: pulse lasts one cycle
    issue(4'h2, 12'h010, 4'b1100, 1'b0);
    checkOut("R10 accept pulse", 3'b100);
    @(negedge clk);
    checkOut("R10 pulse ends", 3'b000);

    // R10: back to back, accept then abort
    @(negedge clk);
    busCmd = 4'h2; destSel = 12'h020; beN = 4'b1100; dataValid = 1'b1;
    @(negedge clk);
    checkOut("R10 back-to-back first", 3'b100);
    beN = 4'b1001;
    @(negedge clk);
    dataValid = 1'b0;
    checkOut("R10 back-to-back second", 3'b010);
    @(negedge clk);
    checkOut("R10 back-to-back end", 3'b000);

    // R11: reset wins over a valid cycle
    @(negedge clk);
    busCmd = 4'h2; destSel = 12'h001; beN = 4'b1110; dataValid = 1'b1;
    ownMasterCyc = 1'b1; rstN = 1'b0;
    @(negedge clk);
    dataValid = 1'b0; ownMasterCyc = 1'b0;
    checkOut("R11 reset masks valid", 3'b000);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R11 quiet after reset", 3'b000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule